// File: doc/BRIEF.md
# Two-Tier Round-Robin Bus Arbiter

This block decides which master may drive a shared parallel bus segment. Six external masters request through active-low lines and receive active-low grants. The bridge's own internal master requests and is granted through an active-high pair. A grant lets the chosen initiator begin a transaction. The arbiter never changes a grant while a transaction is running. It re-arbitrates only at bus-idle edges. Between two different owners it always inserts one clock with no grant.

Each requester is assigned by configuration to a high tier or a low tier. Both tiers rotate round-robin. The low tier as a whole holds one slot in the high-tier rotation, so a low-tier master is never locked out. When nobody requests, the bus is parked. Parking goes either to the last agent granted for a real request or always to the internal master. A tenure timer, reloaded at every grant, runs down only while the bus is busy and some other master is waiting. Once it reaches zero, the owner loses the grant at the next idle edge.

Top module: `two_tier_arbiter`

## Requirements
- R1: While rst_n is low, every grant is inactive. At the first clock edge after release with no requests pending, the internal master (own_gnt) is granted.
- R2: At most one of the seven grants is active in any cycle.
- R3: When ownership moves from one agent to a different one, there is at least one clock with no grant active.
- R4: Agents are indexed 0..5 for ext_req_n[0..5] and 6 for own_req. Within a tier the winner is the first requesting agent found by scanning upward, with wrap, from one past the agent last granted in that tier. Both scan starts point at agent 0 after reset. After reset every agent is in the high tier.
- R5: A requesting high-tier agent is served before any low-tier agent, except when the scan of the high rotation reaches the single slot that stands for the whole low tier. That slot sits after agent 6.
- R6: A low-tier agent that keeps requesting is granted while high-tier agents keep requesting as well. The low tier has its own rotation.
- R7: With park mode 0, when no agent requests, the grant stays with (or returns to) the agent most recently granted for a real request. Before any such grant, this is the internal master.
- R8: With park mode 1, when no agent requests, the grant goes to the internal master, after the idle clock of R3 if another agent held it.
- R9: The tenure timer reloads on every new grant. It decrements on each edge where the bus is busy and an agent other than the owner requests. When it is zero and another agent requests, the still-requesting owner loses its grant at the next bus-idle edge.
- R10: The timer does not count while no other agent requests. An owner that keeps requesting then keeps the grant across any number of busy cycles.
- R11: The grant lines do not change on an edge at which bus_busy is high.
- R12: A configuration write (cfg_wr high) with cfg_sel 0 loads the tier mask from cfg_data[6:0] (1 = high tier, bit 6 = internal master). Selector 1 loads the park mode from cfg_data[0]. Selector 2 loads the timer reload value from cfg_data[7:0]. Reset values are: mask all ones, park mode 0, reload 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_busy | input | 1 | High while a transaction occupies the bus |
| ext_req_n | input | 6 | Active-low requests of the external masters |
| ext_gnt_n | output | 6 | Active-low grants of the external masters |
| own_req | input | 1 | Active-high request of the internal master |
| own_gnt | output | 1 | Active-high grant of the internal master |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration field selector |
| cfg_data | input | 8 | Configuration write data |

## Verification
Timer expiry and the busy-bus hold can fall due together. The timer reaches zero while a transaction is still running, and the arbiter must then keep the grant unchanged rather than pull it. The bench provokes this by keeping bus_busy high for several edges past the point where the count hits zero while a second master waits. It judges the result by a grant that holds through the whole busy stretch, then an empty clock on the first idle edge, then the waiting master's grant. Owner release and parking also meet at one edge. There the bench checks that the parking choice, not the rotation, picks the next grant.

// File: rtl/tta_pkg.sv
package tta_pkg;
    typedef enum logic [1:0] {
        SEL_TIER  = 2'd0,
        SEL_PARK  = 2'd1,
        SEL_TIMER = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/tta_rr_pick.sv
module tta_rr_pick #(
    parameter int N  = 7,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = int'(start) + i;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/tta_cfg.sv
module tta_cfg
    import tta_pkg::*;
#(
    parameter int N_AG    = 7,
    parameter int TMR_W   = 8,
    parameter int TMR_RST = 16,
    parameter int CFG_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       sel,
    input  logic [CFG_W-1:0] data,
    output logic [N_AG-1:0]  tier_hi,
    output logic             park_own,
    output logic [TMR_W-1:0] tmr_load
);
    typedef struct packed {
        logic [N_AG-1:0]  tier;
        logic             park;
        logic [TMR_W-1:0] load;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            unique case (cfg_sel_e'(sel))
                SEL_TIER:  cfg_d.tier = data[N_AG-1:0];
                SEL_PARK:  cfg_d.park = data[0];
                SEL_TIMER: cfg_d.load = data[TMR_W-1:0];
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.tier <= '1;
            cfg_q.park <= 1'b0;
            cfg_q.load <= TMR_W'(TMR_RST);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign tier_hi  = cfg_q.tier;
    assign park_own = cfg_q.park;
    assign tmr_load = cfg_q.load;
endmodule

// File: rtl/two_tier_arbiter.sv
module two_tier_arbiter #(
    parameter int N_EXT   = 6,
    parameter int TMR_W   = 8,
    parameter int TMR_RST = 16,
    parameter int CFG_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_busy,
    input  logic [N_EXT-1:0] ext_req_n,
    output logic [N_EXT-1:0] ext_gnt_n,
    input  logic             own_req,
    output logic             own_gnt,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_data
);
    localparam int N_AG   = N_EXT + 1;
    localparam int OWN    = N_EXT;
    localparam int AW     = $clog2(N_AG);
    localparam int N_HI   = N_AG + 1;
    localparam int HW     = $clog2(N_HI);
    localparam int LO_SLOT = N_AG;

    typedef struct packed {
        logic             gv;
        logic [AW-1:0]    gi;
        logic [AW-1:0]    last;
        logic [HW-1:0]    ptr_hi;
        logic [AW-1:0]    ptr_lo;
        logic [TMR_W-1:0] tmr;
    } arb_t;

    arb_t st_d, st_q;

    logic [N_AG-1:0]  tier_hi;
    logic             park_own;
    logic [TMR_W-1:0] tmr_load;
    logic [N_AG-1:0]  req;
    logic [N_AG-1:0]  lo_vec;
    logic [N_HI-1:0]  hi_vec;
    logic             hi_found, lo_found;
    logic [HW-1:0]    hi_idx;
    logic [AW-1:0]    lo_idx;
    logic [N_AG-1:0]  gnt_vec;

    tta_cfg #(.N_AG(N_AG), .TMR_W(TMR_W), .TMR_RST(TMR_RST), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .data(cfg_data),
        .tier_hi(tier_hi), .park_own(park_own), .tmr_load(tmr_load)
    );

    assign req    = {own_req, ~ext_req_n};
    assign lo_vec = req & ~tier_hi;
    assign hi_vec = {|lo_vec, req & tier_hi};

    tta_rr_pick #(.N(N_HI)) u_pick_hi (
        .req(hi_vec), .start(st_q.ptr_hi), .found(hi_found), .idx(hi_idx)
    );
    tta_rr_pick #(.N(N_AG)) u_pick_lo (
        .req(lo_vec), .start(st_q.ptr_lo), .found(lo_found), .idx(lo_idx)
    );

    always_comb begin
        logic            use_lo;
        logic [AW-1:0]   winner;
        logic [AW-1:0]   park_to;
        logic [N_AG-1:0] owner_bit;
        logic            others;
        logic            owner_req;
        logic            keep;

        use_lo    = hi_found && (hi_idx == HW'(LO_SLOT)) && lo_found;
        winner    = use_lo ? lo_idx : hi_idx[AW-1:0];
        park_to   = park_own ? AW'(OWN) : st_q.last;
        owner_bit = st_q.gv ? (N_AG'(1) << st_q.gi) : '0;
        others    = |(req & ~owner_bit);
        owner_req = |(req & owner_bit);
        keep      = owner_req && !((st_q.tmr == '0) && others);

        st_d = st_q;
        if (st_q.gv && bus_busy && others && (st_q.tmr != '0))
            st_d.tmr = st_q.tmr - 1'b1;

        if (!bus_busy) begin
            if (st_q.gv) begin
                if (!keep) begin
                    if (hi_found) begin
                        if (winner != st_q.gi) st_d.gv = 1'b0;
                    end else if (park_to != st_q.gi) begin
                        st_d.gv = 1'b0;
                    end
                end
            end else if (hi_found) begin
                st_d.gv   = 1'b1;
                st_d.gi   = winner;
                st_d.last = winner;
                st_d.tmr  = tmr_load;
                if (use_lo) begin
                    st_d.ptr_hi = HW'((LO_SLOT + 1) % N_HI);
                    st_d.ptr_lo = (lo_idx == AW'(N_AG - 1)) ? '0 : lo_idx + 1'b1;
                end else begin
                    st_d.ptr_hi = (hi_idx == HW'(N_HI - 1)) ? '0 : hi_idx + 1'b1;
                end
            end else begin
                st_d.gv  = 1'b1;
                st_d.gi  = park_to;
                st_d.tmr = tmr_load;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gv     <= 1'b0;
            st_q.gi     <= '0;
            st_q.last   <= AW'(OWN);
            st_q.ptr_hi <= '0;
            st_q.ptr_lo <= '0;
            st_q.tmr    <= TMR_W'(TMR_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_vec   = st_q.gv ? (N_AG'(1) << st_q.gi) : '0;
    assign ext_gnt_n = ~gnt_vec[N_EXT-1:0];
    assign own_gnt   = gnt_vec[OWN];
endmodule

// File: rtl/tta_chk.sv
module tta_chk #(
    parameter int N_AG = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_busy,
    input logic [N_AG-1:0] gnt_vec
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (gnt_vec == '0); // R1
        end
    end

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_vec)); // R2

    AST_HANDOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(gnt_vec) != '0) && (gnt_vec != '0)) |-> (gnt_vec == $past(gnt_vec))); // R3

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> $stable(gnt_vec)); // R11
endmodule

bind two_tier_arbiter tta_chk #(.N_AG(N_AG)) u_tta_chk (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .gnt_vec(gnt_vec)
);

// File: tb/tb_two_tier_arbiter.sv
module tb_two_tier_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_busy = 1'b0;
    logic [5:0] ext_req_n = '1;
    logic [5:0] ext_gnt_n;
    logic       own_req = 1'b0;
    logic       own_gnt;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_data = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    two_tier_arbiter dut (
        .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy),
        .ext_req_n(ext_req_n), .ext_gnt_n(ext_gnt_n),
        .own_req(own_req), .own_gnt(own_gnt),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data)
    );

    localparam logic [6:0] NONE = 7'b0000000;
    localparam logic [6:0] OWNG = 7'b1000000;

    function automatic logic [6:0] ag(input int k);
        return 7'(1) << k;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [6:0] exp);
        logic [6:0] act;
        act = {own_gnt, ~ext_gnt_n};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: grants actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = data;
        tick(1);
        cfg_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_busy = 1'b0; ext_req_n = '1; own_req = 1'b0; cfg_wr = 1'b0;
        tick(2);
        chk("R1 reset quiet", NONE);
        rst_n = 1'b1;
        tick(1);
        chk("R1 first park on internal", OWNG);
    endtask

    task automatic pulse_ext(input int k, input logic [6:0] exp, input string tag);
        ext_req_n[k] = 1'b1;
        tick(1);
        chk("R3 gap on release", NONE);
        ext_req_n[k] = 1'b0;
        tick(1);
        chk(tag, exp);
    endtask

    task automatic test_rotation();
        do_reset();
        ext_req_n[0] = 1'b0; ext_req_n[2] = 1'b0; ext_req_n[4] = 1'b0;
        tick(1); chk("R3 gap from park", NONE);
        tick(1); chk("R4 first from 0", ag(0));
        ext_req_n[0] = 1'b1;
        tick(1); chk("R3 gap", NONE);
        tick(1); chk("R4 next is 2", ag(2));
        ext_req_n[2] = 1'b1;
        tick(1); chk("R3 gap", NONE);
        tick(1); chk("R4 next is 4", ag(4));
        ext_req_n[4] = 1'b1; ext_req_n[1] = 1'b0; ext_req_n[5] = 1'b0;
        tick(1); chk("R3 gap", NONE);
        tick(1); chk("R4 scan starts past 4", ag(5));
    endtask

    task automatic test_tiers();
        do_reset();
        cfg_write(2'd0, 8'b0000_0011);   // R12 tier mask: 0,1 high
        chk("R12 no grant change on idle write", OWNG);
        ext_req_n[0] = 1'b0; ext_req_n[1] = 1'b0; ext_req_n[3] = 1'b0; ext_req_n[4] = 1'b0;
        tick(1); chk("R3 gap", NONE);
        tick(1); chk("R5 high tier first", ag(0));
        pulse_ext(0, ag(1), "R5 high before low");
        pulse_ext(1, ag(3), "R6 low slot gets a turn");
        pulse_ext(3, ag(0), "R5 back to high tier");
        pulse_ext(0, ag(1), "R5 high rotation");
        pulse_ext(1, ag(4), "R6 low rotation past 3");
    endtask

    task automatic test_park();
        do_reset();
        cfg_write(2'd1, 8'h01);          // R12 park on internal master
        ext_req_n[2] = 1'b0;
        tick(1); chk("R3 gap", NONE);
        tick(1); chk("R8 request served", ag(2));
        ext_req_n[2] = 1'b1;
        tick(1); chk("R8 gap before park", NONE);
        tick(1); chk("R8 park on internal", OWNG);
        tick(3); chk("R8 stays parked", OWNG);
        do_reset();
        ext_req_n[2] = 1'b0;
        tick(2); chk("R7 request served", ag(2));
        ext_req_n[2] = 1'b1;
        tick(3); chk("R7 park on last granted", ag(2));
    endtask

    task automatic test_timer();
        do_reset();
        cfg_write(2'd2, 8'd3);           // R12 timer reload 3
        ext_req_n[0] = 1'b0;
        tick(2); chk("R9 owner granted", ag(0));
        bus_busy = 1'b1;
        tick(6); chk("R10 alone while busy", ag(0));
        bus_busy = 1'b0; ext_req_n[1] = 1'b0;
        tick(2); chk("R10 timer not spent", ag(0));
        bus_busy = 1'b1;
        tick(5); chk("R11 held while busy past expiry", ag(0));
        bus_busy = 1'b0;
        tick(1); chk("R9 expiry gap", NONE);
        tick(1); chk("R9 waiting master granted", ag(1));
        bus_busy = 1'b1;
        tick(2); chk("R11 held while busy", ag(1));
        bus_busy = 1'b0;
        tick(2); chk("R9 reload on new grant", ag(1));
    endtask

    initial begin
        test_rotation();
        test_tiers();
        test_park();
        test_timer();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule